// File: doc/BRIEF.md
# Joint Translation Buffer with Register Command Interface

This block holds a set-associative table of address translations that software maintains through four registers: two page descriptor registers (the virtual half carrying page number, address-space ID, valid and global bits; the physical half carrying frame number and access rights), an index register and a command register. A command is issued by writing its code to the command register and completes at that clock edge. Software can search the table for a key, ask for a slot to fill, store or load the entry that the index register points at, and clear a small fully associative micro-buffer.

The micro-buffer has four entries and sits on the translation port. A translation request is checked against it first. On a micro miss it falls back to the joint table, and when exactly one way there matches, it copies that entry into the micro-buffer in rotating order. Only the normal store command and the explicit clear command empty the micro-buffer. The second store command keeps it, so entries pushed out of a busy set of the joint table can still translate from the micro-buffer.

Top module: `jtlb_top`

## Requirements
- R1: After reset the three register read-backs are zero, every table entry is invalid, a search reports a miss and a translation reports a miss.
- R2: Register select 0 writes the virtual descriptor, which keeps bits 28:0 (ASID in 7:0, valid in 8, global in 9, virtual page in 28:10). Select 1 writes the physical descriptor, which keeps bits 24:0 (rights in 5:0, frame in 24:6). Select 2 writes the index register, which keeps bit 31 (error), bit 30 (duplicate) and index bits 7:0. Select 3 issues the command held in bits 2:0. Every other read-back bit is zero.
- R3: The entry index is set × WAYS + way. The set is the low 7 bits of the virtual page, so the ways of one set sit at consecutive indices.
- R4: Search (command 1) matches valid entries of the set that have an equal virtual page and either an equal ASID or the global bit. A single match loads its index and clears both flags.
- R5: A search with no match leaves the index register at 0x80000000. A search with more than one matching way leaves 0xC0000000.
- R6: Get-slot (command 2) loads the index of the lowest invalid way of the virtual descriptor's set. When all ways are valid it loads the way named by that set's rotating pointer, which starts at 0 and advances by one at each such choice.
- R7: Store (command 3) writes both descriptors into the indexed entry and empties the micro-buffer.
- R8: When index bit 31 is set, store, store-keep and load leave the table and the descriptor registers unchanged.
- R9: Load (command 5) copies the indexed entry into both descriptor registers.
- R10: Micro-clear (command 6) empties the micro-buffer and leaves the table unchanged.
- R11: One cycle after a translation request the block raises the acknowledge together with exactly one of hit and miss. On a hit it gives frame and rights, from the micro-buffer first and otherwise from a single matching table way. No match or a duplicate in the table gives a miss.
- R12: Store-keep (command 4) writes the entry and leaves the micro-buffer untouched. The micro-buffer holds 4 entries, is filled on a micro miss with a single table hit, and is replaced in rotating order from slot 0.
- R13: When a store or micro-clear command falls in the same cycle as a translation, the translation answers from the contents before the command and no refill is kept. A store-keep in the same cycle keeps the refill.
- R14: Command codes 0 and 7 change no register, table entry or micro-buffer entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 virtual, 1 physical, 2 index, 3 command) |
| reg_wdata | input | 32 | Register write data |
| pd0_o | output | 32 | Virtual descriptor read-back |
| pd1_o | output | 32 | Physical descriptor read-back |
| idx_o | output | 32 | Index register read-back with error and duplicate flags |
| xl_req | input | 1 | Translation request |
| xl_vpn | input | 19 | Virtual page to translate |
| xl_asid | input | 8 | Current address-space ID |
| xl_ack | output | 1 | Translation answer valid, one cycle after request |
| xl_hit | output | 1 | Translation found |
| xl_miss | output | 1 | Translation not found or ambiguous |
| xl_pfn | output | 19 | Translated frame number |
| xl_perm | output | 6 | Access rights of the translation |

## Verification
A translation that refills the micro-buffer and a command that clears it can fall in the same cycle. The bench issues a micro-clear, a store and a store-keep on the same clock edge as a translation whose key misses the micro-buffer but hits the table. It checks that the answer in that cycle reflects the old contents. It then removes the table entry with store-keep and translates again: a miss shows the refill was dropped, and a hit shows it was kept.

// File: rtl/jtlb_pkg.sv
package jtlb_pkg;
  localparam int unsigned VPN_W  = 19;
  localparam int unsigned PFN_W  = 19;
  localparam int unsigned ASID_W = 8;
  localparam int unsigned PERM_W = 6;
  localparam int unsigned REG_W  = 32;

  localparam int unsigned PD0_W     = ASID_W + 2 + VPN_W;
  localparam int unsigned PD1_W     = PERM_W + PFN_W;
  localparam int unsigned PD0_VLD_B = ASID_W;
  localparam int unsigned PD0_GLB_B = ASID_W + 1;
  localparam int unsigned PD0_VPN_B = ASID_W + 2;
  localparam int unsigned IDX_ERR_B = REG_W - 1;
  localparam int unsigned IDX_DUP_B = REG_W - 2;

  typedef enum logic [1:0] {
    SEL_PD0 = 2'd0,
    SEL_PD1 = 2'd1,
    SEL_IDX = 2'd2,
    SEL_CMD = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    CMD_NOP0   = 3'd0,
    CMD_PROBE  = 3'd1,
    CMD_GETIDX = 3'd2,
    CMD_WRITE  = 3'd3,
    CMD_WKEEP  = 3'd4,
    CMD_READ   = 3'd5,
    CMD_UFLUSH = 3'd6,
    CMD_NOP7   = 3'd7
  } tlb_cmd_e;

  typedef struct packed {
    logic              vld;
    logic              glb;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } tlb_ent_t;

  // Key comparison shared by the joint table and the micro-buffer.
  function automatic logic ent_match(tlb_ent_t e, logic [VPN_W-1:0] vpn,
                                     logic [ASID_W-1:0] asid);
    return e.vld && (e.vpn == vpn) && (e.glb || (e.asid == asid));
  endfunction

  function automatic tlb_ent_t ent_from_regs(logic [PD0_W-1:0] pd0,
                                             logic [PD1_W-1:0] pd1);
    tlb_ent_t e;
    e.asid = pd0[ASID_W-1:0];
    e.vld  = pd0[PD0_VLD_B];
    e.glb  = pd0[PD0_GLB_B];
    e.vpn  = pd0[PD0_VPN_B +: VPN_W];
    e.perm = pd1[PERM_W-1:0];
    e.pfn  = pd1[PERM_W +: PFN_W];
    return e;
  endfunction

  function automatic logic [PD0_W-1:0] ent_to_pd0(tlb_ent_t e);
    return {e.vpn, e.glb, e.vld, e.asid};
  endfunction

  function automatic logic [PD1_W-1:0] ent_to_pd1(tlb_ent_t e);
    return {e.pfn, e.perm};
  endfunction
endpackage

// File: rtl/jtlb_array.sv
module jtlb_array
  import jtlb_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = SET_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  tlb_ent_t          wr_ent,
  input  logic [IDX_W-1:0]  rd_idx,
  output tlb_ent_t          rd_ent,
  input  logic [SET_W-1:0]  pr_set,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic [WAYS-1:0]   pr_hit,
  output logic [WAYS-1:0]   pr_vld,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic [WAYS-1:0]   lk_hit,
  output tlb_ent_t          lk_ent [WAYS]
);
  localparam int ENT_N = SETS * WAYS;

  // Linear index: set * WAYS + way (WAYS is a power of two).
  function automatic logic [IDX_W-1:0] f_lin(logic [SET_W-1:0] s, logic [WAY_W-1:0] w);
    return {s, w};
  endfunction

  tlb_ent_t mem [ENT_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT_N; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_ent;
    end
  end

  assign rd_ent = mem[rd_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_ent_t pr_e;
    assign pr_e      = mem[f_lin(pr_set, WAY_W'(w))];
    assign pr_hit[w] = ent_match(pr_e, pr_vpn, pr_asid);
    assign pr_vld[w] = pr_e.vld;
    assign lk_ent[w] = mem[f_lin(lk_set, WAY_W'(w))];
    assign lk_hit[w] = ent_match(lk_ent[w], lk_vpn, lk_asid);
  end
endmodule

// File: rtl/jtlb_victim.sv
module jtlb_victim #(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set,
  input  logic [WAYS-1:0]  vld,
  input  logic             take,
  output logic [WAY_W-1:0] way
);
  logic [WAY_W-1:0] rr [SETS];
  logic [WAY_W-1:0] first_inv;
  logic             all_vld;

  function automatic logic [WAY_W-1:0] f_next(logic [WAY_W-1:0] p);
    return (p == WAY_W'(WAYS - 1)) ? '0 : p + WAY_W'(1);
  endfunction

  always_comb begin
    first_inv = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[w]) first_inv = WAY_W'(w);
    end
  end

  assign all_vld = &vld;
  assign way     = all_vld ? rr[set] : first_inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr[s] <= '0;
    end else if (take && all_vld) begin
      rr[set] <= f_next(rr[set]);
    end
  end
endmodule

// File: rtl/jtlb_utlb.sv
module jtlb_utlb
  import jtlb_pkg::*;
#(
  parameter int UTLB_N = 4,
  localparam int PTR_W = (UTLB_N > 1) ? $clog2(UTLB_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output tlb_ent_t          hit_ent,
  input  logic              fill,
  input  tlb_ent_t          fill_ent,
  input  logic              flush,
  output logic [UTLB_N-1:0] vld_o
);
  tlb_ent_t          ent [UTLB_N];
  logic [UTLB_N-1:0] vld;
  logic [PTR_W-1:0]  ptr;

  function automatic logic [PTR_W-1:0] f_bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(UTLB_N - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    hit     = 1'b0;
    hit_ent = '0;
    for (int i = UTLB_N - 1; i >= 0; i--) begin
      if (vld[i] && ent_match(ent[i], lk_vpn, lk_asid)) begin
        hit     = 1'b1;
        hit_ent = ent[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
      for (int i = 0; i < UTLB_N; i++) ent[i] <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (fill) begin
      ent[ptr] <= fill_ent;
      vld[ptr] <= 1'b1;
      ptr      <= f_bump(ptr);
    end
  end

  assign vld_o = vld;
endmodule

// File: rtl/jtlb_top.sv
module jtlb_top
  import jtlb_pkg::*;
#(
  parameter int SETS   = 128,
  parameter int WAYS   = 2,
  parameter int UTLB_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  pd0_o,
  output logic [REG_W-1:0]  pd1_o,
  output logic [REG_W-1:0]  idx_o,
  input  logic              xl_req,
  input  logic [VPN_W-1:0]  xl_vpn,
  input  logic [ASID_W-1:0] xl_asid,
  output logic              xl_ack,
  output logic              xl_hit,
  output logic              xl_miss,
  output logic [PFN_W-1:0]  xl_pfn,
  output logic [PERM_W-1:0] xl_perm
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = SET_W + WAY_W;

  function automatic logic [IDX_W-1:0] f_lin(logic [SET_W-1:0] s, logic [WAY_W-1:0] w);
    return {s, w};
  endfunction

  // software-visible registers
  logic [PD0_W-1:0] pd0_q;
  logic [PD1_W-1:0] pd1_q;
  logic [IDX_W-1:0] idx_q;
  logic             idx_err_q, idx_dup_q;

  // command decode
  tlb_cmd_e cmd;
  logic     cmd_go;
  logic     ev_probe, ev_getidx, ev_store, ev_keep, ev_read, ev_uflush;

  assign cmd       = tlb_cmd_e'(reg_wdata[2:0]);
  assign cmd_go    = reg_we && (reg_sel_e'(reg_sel) == SEL_CMD);
  assign ev_probe  = cmd_go && (cmd == CMD_PROBE);
  assign ev_getidx = cmd_go && (cmd == CMD_GETIDX);
  assign ev_keep   = cmd_go && (cmd == CMD_WKEEP);
  assign ev_store  = cmd_go && ((cmd == CMD_WRITE) || (cmd == CMD_WKEEP)) && !idx_err_q;
  assign ev_read   = cmd_go && (cmd == CMD_READ) && !idx_err_q;
  assign ev_uflush = cmd_go && ((cmd == CMD_WRITE) || (cmd == CMD_UFLUSH));

  // key from the virtual descriptor
  logic [VPN_W-1:0]  key_vpn;
  logic [ASID_W-1:0] key_asid;
  logic [SET_W-1:0]  key_set;
  assign key_vpn  = pd0_q[PD0_VPN_B +: VPN_W];
  assign key_asid = pd0_q[ASID_W-1:0];
  assign key_set  = key_vpn[SET_W-1:0];

  // joint table
  tlb_ent_t          rd_ent;
  logic [WAYS-1:0]   pr_hit, pr_vld, lk_hit;
  tlb_ent_t          lk_ent [WAYS];

  jtlb_array #(.SETS(SETS), .WAYS(WAYS)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ev_store),
    .wr_idx (idx_q),
    .wr_ent (ent_from_regs(pd0_q, pd1_q)),
    .rd_idx (idx_q),
    .rd_ent (rd_ent),
    .pr_set (key_set),
    .pr_vpn (key_vpn),
    .pr_asid(key_asid),
    .pr_hit (pr_hit),
    .pr_vld (pr_vld),
    .lk_set (xl_vpn[SET_W-1:0]),
    .lk_vpn (xl_vpn),
    .lk_asid(xl_asid),
    .lk_hit (lk_hit),
    .lk_ent (lk_ent)
  );

  // victim choice for get-slot
  logic [WAY_W-1:0] vic_way;
  jtlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (key_set),
    .vld  (pr_vld),
    .take (ev_getidx),
    .way  (vic_way)
  );

  // way encoders and match counts
  logic [WAY_W-1:0] pr_way, lk_way;
  int unsigned      pr_cnt, lk_cnt;
  always_comb begin
    pr_way = '0;
    lk_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (pr_hit[w]) pr_way = WAY_W'(w);
      if (lk_hit[w]) lk_way = WAY_W'(w);
    end
  end
  assign pr_cnt = $countones(pr_hit);
  assign lk_cnt = $countones(lk_hit);

  // micro-buffer
  logic              u_hit;
  tlb_ent_t          u_ent;
  logic              j_single;
  tlb_ent_t          j_ent;
  logic              ev_refill;
  logic [UTLB_N-1:0] utlb_vld;

  assign j_single  = (lk_cnt == 1);
  assign j_ent     = lk_ent[lk_way];
  assign ev_refill = xl_req && !u_hit && j_single && !ev_uflush;

  jtlb_utlb #(.UTLB_N(UTLB_N)) u_utlb (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_vpn  (xl_vpn),
    .lk_asid (xl_asid),
    .hit     (u_hit),
    .hit_ent (u_ent),
    .fill    (ev_refill),
    .fill_ent(j_ent),
    .flush   (ev_uflush),
    .vld_o   (utlb_vld)
  );

  // register and command updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd0_q     <= '0;
      pd1_q     <= '0;
      idx_q     <= '0;
      idx_err_q <= 1'b0;
      idx_dup_q <= 1'b0;
    end else if (reg_we) begin
      unique case (reg_sel_e'(reg_sel))
        SEL_PD0: pd0_q <= reg_wdata[PD0_W-1:0];
        SEL_PD1: pd1_q <= reg_wdata[PD1_W-1:0];
        SEL_IDX: begin
          idx_q     <= reg_wdata[IDX_W-1:0];
          idx_err_q <= reg_wdata[IDX_ERR_B];
          idx_dup_q <= reg_wdata[IDX_DUP_B];
        end
        SEL_CMD: begin
          if (ev_probe) begin
            if (pr_cnt == 1) begin
              idx_q     <= f_lin(key_set, pr_way);
              idx_err_q <= 1'b0;
              idx_dup_q <= 1'b0;
            end else begin
              idx_q     <= '0;
              idx_err_q <= 1'b1;
              idx_dup_q <= (pr_cnt > 1);
            end
          end
          if (ev_getidx) begin
            idx_q     <= f_lin(key_set, vic_way);
            idx_err_q <= 1'b0;
            idx_dup_q <= 1'b0;
          end
          if (ev_read) begin
            pd0_q <= ent_to_pd0(rd_ent);
            pd1_q <= ent_to_pd1(rd_ent);
          end
        end
        default: ;
      endcase
    end
  end

  // translation answer, one cycle after the request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_ack  <= 1'b0;
      xl_hit  <= 1'b0;
      xl_miss <= 1'b0;
      xl_pfn  <= '0;
      xl_perm <= '0;
    end else begin
      xl_ack  <= xl_req;
      xl_hit  <= xl_req && (u_hit || j_single);
      xl_miss <= xl_req && !(u_hit || j_single);
      if (xl_req && u_hit) begin
        xl_pfn  <= u_ent.pfn;
        xl_perm <= u_ent.perm;
      end else if (xl_req && j_single) begin
        xl_pfn  <= j_ent.pfn;
        xl_perm <= j_ent.perm;
      end else begin
        xl_pfn  <= '0;
        xl_perm <= '0;
      end
    end
  end

  assign pd0_o = REG_W'(pd0_q);
  assign pd1_o = REG_W'(pd1_q);
  assign idx_o = {idx_err_q, idx_dup_q, {(REG_W - 2 - IDX_W){1'b0}}, idx_q};

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/jtlb_chk.sv
module jtlb_chk #(
  parameter int SETS   = 128,
  parameter int WAYS   = 2,
  parameter int UTLB_N = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = SET_W + WAY_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xl_req,
  input logic              xl_ack,
  input logic              xl_hit,
  input logic              xl_miss,
  input logic [UTLB_N-1:0] utlb_vld,
  input logic              ev_uflush,
  input logic              ev_keep,
  input logic              ev_probe,
  input logic              ev_getidx,
  input logic [WAYS-1:0]   pr_hit,
  input logic [SET_W-1:0]  key_set,
  input logic [31:0]       idx_o
);
  p_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_ack);

  p_one_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xl_ack |-> $onehot({xl_hit, xl_miss}));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_ack |-> !xl_hit && !xl_miss);

  // covers R7, R10 and the dropped refill of R13
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_uflush |=> (utlb_vld == '0));

  p_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_keep |=> ((utlb_vld & $past(utlb_vld)) == $past(utlb_vld)));

  p_miss_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_probe && (pr_hit == '0)) |=> (idx_o[31:30] == 2'b10));

  p_dup_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_probe && ($countones(pr_hit) > 1)) |=> (idx_o[31:30] == 2'b11));

  p_slot_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_getidx |=> (idx_o[31:30] == 2'b00) && (idx_o[IDX_W-1:WAY_W] == $past(key_set)));
endmodule

bind jtlb_top jtlb_chk #(.SETS(SETS), .WAYS(WAYS), .UTLB_N(UTLB_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .xl_req   (xl_req),
  .xl_ack   (xl_ack),
  .xl_hit   (xl_hit),
  .xl_miss  (xl_miss),
  .utlb_vld (utlb_vld),
  .ev_uflush(ev_uflush),
  .ev_keep  (ev_keep),
  .ev_probe (ev_probe),
  .ev_getidx(ev_getidx),
  .pr_hit   (pr_hit),
  .key_set  (key_set),
  .idx_o    (idx_o)
);

// File: tb/jtlb_top_tb.sv
`timescale 1ns/1ps
module jtlb_top_tb;
  localparam int SETS = 128;
  localparam int WAYS = 2;
  localparam int NENT = SETS * WAYS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] pd0_o, pd1_o, idx_o;
  logic        xl_req = 1'b0;
  logic [18:0] xl_vpn = '0;
  logic [7:0]  xl_asid = '0;
  logic        xl_ack, xl_hit, xl_miss;
  logic [18:0] xl_pfn;
  logic [5:0]  xl_perm;

  always #10 clk = ~clk;

  jtlb_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .pd0_o(pd0_o), .pd1_o(pd1_o), .idx_o(idx_o),
    .xl_req(xl_req), .xl_vpn(xl_vpn), .xl_asid(xl_asid),
    .xl_ack(xl_ack), .xl_hit(xl_hit), .xl_miss(xl_miss), .xl_pfn(xl_pfn), .xl_perm(xl_perm)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_pd0 [NENT];
  logic [31:0] m_pd1 [NENT];
  int          m_rr  [SETS];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk0(int vpn, int asid, bit v, bit g);
    return (32'(vpn) << 10) | (32'(g) << 9) | (32'(v) << 8) | 32'(asid & 8'hff);
  endfunction

  function automatic logic [31:0] mk1(int pfn, int perm);
    return (32'(pfn) << 6) | 32'(perm & 6'h3f);
  endfunction

  // bench restatement of the match rule and search result codes
  function automatic bit m_hit(logic [31:0] e, int vpn, int asid);
    return e[8] && (int'(e[28:10]) == vpn) && (e[9] || (int'(e[7:0]) == asid));
  endfunction

  function automatic int m_count(int vpn, int asid, output int where);
    int c = 0;
    where = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (m_hit(m_pd0[(vpn % SETS) * WAYS + w], vpn, asid)) begin
        if (c == 0) where = (vpn % SETS) * WAYS + w;
        c++;
      end
    end
    return c;
  endfunction

  function automatic logic [31:0] m_probe(int vpn, int asid);
    int where;
    int c = m_count(vpn, asid, where);
    if (c == 1) return 32'(where);
    return (c == 0) ? 32'h8000_0000 : 32'hC000_0000;
  endfunction

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cmd(input int c);
    wr(3, 32'(c));
  endtask

  task automatic put(input int idx, input logic [31:0] p0, input logic [31:0] p1, input bit keep);
    wr(2, 32'(idx));
    wr(0, p0);
    wr(1, p1);
    cmd(keep ? 4 : 3);
    m_pd0[idx] = p0 & 32'h1FFF_FFFF;
    m_pd1[idx] = p1 & 32'h01FF_FFFF;
  endtask

  task automatic probe(input int vpn, input int asid, input string req);
    logic [31:0] e = m_probe(vpn, asid);
    wr(0, mk0(vpn, asid, 1'b0, 1'b0));
    cmd(1);
    chk(idx_o == e, req, idx_o, e);
  endtask

  // request in one cycle, sample the registered answer one cycle later
  task automatic xlate(input int vpn, input int asid, input bit exp_hit, input int exp_pfn, input string req);
    @(negedge clk);
    xl_req = 1'b1; xl_vpn = 19'(vpn); xl_asid = 8'(asid);
    @(negedge clk);
    xl_req = 1'b0;
    chk(xl_ack && (xl_hit == exp_hit) && (xl_miss == !exp_hit) &&
        (!exp_hit || (int'(xl_pfn) == exp_pfn)),
        req, {xl_ack, xl_hit, xl_miss, 10'd0, xl_pfn}, {1'b1, exp_hit, !exp_hit, 10'd0, 19'(exp_pfn)});
  endtask

  // command and translation in the same cycle
  task automatic cmd_xlate(input int c, input int vpn, input int asid, input bit exp_hit, input int exp_pfn, input string req);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'(c);
    xl_req = 1'b1; xl_vpn = 19'(vpn); xl_asid = 8'(asid);
    @(negedge clk);
    reg_we = 1'b0; xl_req = 1'b0;
    chk(xl_ack && (xl_hit == exp_hit) && (!exp_hit || (int'(xl_pfn) == exp_pfn)),
        req, {xl_hit, 12'd0, xl_pfn}, {exp_hit, 12'd0, 19'(exp_pfn)});
  endtask

  task automatic getidx(input int vpn, input string req);
    int s = vpn % SETS;
    int w = -1;
    logic [31:0] e;
    for (int k = WAYS - 1; k >= 0; k--) if (!m_pd0[s * WAYS + k][8]) w = k;
    if (w < 0) begin
      w = m_rr[s];
      m_rr[s] = (m_rr[s] + 1) % WAYS;
    end
    e = 32'(s * WAYS + w);
    wr(0, mk0(vpn, 0, 1'b0, 1'b0));
    cmd(2);
    chk(idx_o == e, req, idx_o, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] sv0, sv1;
    void'($urandom(32'd4242));
    for (int i = 0; i < NENT; i++) begin m_pd0[i] = '0; m_pd1[i] = '0; end
    for (int s = 0; s < SETS; s++) m_rr[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pd0_o == 0 && pd1_o == 0 && idx_o == 0, "R1 regs", pd0_o | pd1_o | idx_o, 32'd0);
    xlate(7, 1, 1'b0, 0, "R1 translate miss");
    probe(7, 1, "R1 R5 search miss");

    // R2 register layout
    wr(0, 32'hFFFF_FFFF); chk(pd0_o == 32'h1FFF_FFFF, "R2 pd0", pd0_o, 32'h1FFF_FFFF);
    wr(1, 32'hFFFF_FFFF); chk(pd1_o == 32'h01FF_FFFF, "R2 pd1", pd1_o, 32'h01FF_FFFF);
    wr(2, 32'hFFFF_FFFF); chk(idx_o == 32'hC000_00FF, "R2 idx", idx_o, 32'hC000_00FF);
    wr(2, 0);

    // R6 R3 get-slot: free ways first, then rotation
    getidx(5, "R6 R3 first free");
    put(10, mk0(5, 1, 1, 0), mk1(19'h111, 6'h07), 1'b0);
    getidx(5, "R6 second free");
    put(11, mk0(133, 2, 1, 1), mk1(19'h222, 6'h38), 1'b0);
    getidx(5, "R6 rotate way0");
    getidx(5, "R6 rotate way1");
    getidx(5, "R6 rotate wrap");

    // R4 search
    probe(5, 1, "R4 single hit");
    probe(5, 2, "R4 asid mismatch");
    probe(133, 9, "R4 global hit");
    put(11, mk0(5, 2, 1, 1), mk1(19'h222, 6'h38), 1'b0);
    probe(5, 1, "R5 duplicate");

    // R9 load
    wr(2, 10); cmd(5);
    chk(pd0_o == m_pd0[10] && pd1_o == m_pd1[10], "R9 load", pd1_o, m_pd1[10]);

    // R8 error flag blocks store and load
    wr(0, mk0(77, 3, 1, 0)); wr(1, mk1(5, 5));
    wr(2, 32'h8000_000A); cmd(3); cmd(5);
    chk(pd0_o == mk0(77, 3, 1, 0), "R8 load blocked", pd0_o, mk0(77, 3, 1, 0));
    wr(2, 10); cmd(5);
    chk(pd0_o == m_pd0[10], "R8 store blocked", pd0_o, m_pd0[10]);

    // R14 reserved codes
    sv0 = pd0_o; sv1 = pd1_o;
    cmd(0); cmd(7);
    chk(pd0_o == sv0 && pd1_o == sv1 && idx_o == 32'd10, "R14 no change", idx_o, 32'd10);
    cmd(5);
    chk(pd1_o == m_pd1[10], "R14 entry kept", pd1_o, m_pd1[10]);

    // R12 R7 stale micro entry survives store-keep, not store
    cmd(6);
    put(20, mk0(10, 3, 1, 0), mk1(19'h0ABC, 6'h15), 1'b0);
    xlate(10, 3, 1'b1, 19'h0ABC, "R11 table hit");
    put(20, 32'd0, 32'd0, 1'b1);
    xlate(10, 3, 1'b1, 19'h0ABC, "R12 stale micro hit");
    put(20, 32'd0, 32'd0, 1'b0);
    xlate(10, 3, 1'b0, 0, "R7 micro emptied");

    // R10 micro-clear keeps the table
    put(22, mk0(11, 3, 1, 0), mk1(19'h0BCD, 6'h01), 1'b0);
    xlate(11, 3, 1'b1, 19'h0BCD, "R10 prefill");
    cmd(6);
    probe(11, 3, "R10 table kept");
    put(22, 32'd0, 32'd0, 1'b1);
    xlate(11, 3, 1'b0, 0, "R10 micro empty");

    // R12 four entries, rotating replacement
    cmd(6);
    for (int k = 0; k < 5; k++) put((30 + k) * 2, mk0(30 + k, 1, 1, 0), mk1(19'h300 + k, 6'h02), 1'b0);
    for (int k = 0; k < 5; k++) xlate(30 + k, 1, 1'b1, 19'h300 + k, "R12 fill");
    for (int k = 0; k < 5; k++) put((30 + k) * 2, 32'd0, 32'd0, 1'b1);
    xlate(30, 1, 1'b0, 0, "R12 oldest replaced");
    for (int k = 1; k < 5; k++) xlate(30 + k, 1, 1'b1, 19'h300 + k, "R12 survivors");

    // R13 same-cycle command and refill
    cmd(6);
    put(80, mk0(40, 4, 1, 0), mk1(19'h4444, 6'h11), 1'b1);
    cmd_xlate(6, 40, 4, 1'b1, 19'h4444, "R13 answer during clear");
    put(80, 32'd0, 32'd0, 1'b1);
    xlate(40, 4, 1'b0, 0, "R13 refill dropped by clear");
    put(80, mk0(40, 4, 1, 0), mk1(19'h4444, 6'h11), 1'b1);
    wr(2, 90);
    cmd_xlate(4, 40, 4, 1'b1, 19'h4444, "R13 answer during keep");
    m_pd0[90] = m_pd0[90] & 32'h1FFF_FFFF;
    put(80, 32'd0, 32'd0, 1'b1);
    xlate(40, 4, 1'b1, 19'h4444, "R13 refill kept by keep");
    cmd(6);
    put(80, mk0(40, 4, 1, 0), mk1(19'h4444, 6'h11), 1'b1);
    wr(0, 0); wr(1, 0);
    cmd_xlate(3, 40, 4, 1'b1, 19'h4444, "R13 answer from old contents");
    m_pd0[80] = 0; m_pd1[80] = 0;
    xlate(40, 4, 1'b0, 0, "R13 store removed entry");

    // random mix over a few dense sets
    for (int it = 0; it < 400; it++) begin
      int op   = $urandom % 5;
      int s    = $urandom % 4;
      int vpn  = s + SETS * ($urandom % 2);
      int asid = 1 + $urandom % 2;
      case (op)
        0: put(s * WAYS + $urandom % WAYS, mk0(vpn, asid, ($urandom % 4) != 0, ($urandom % 4) == 0),
               mk1($urandom % 524288, $urandom % 64), $urandom % 2);
        1: probe(vpn, asid, "R4 R5 random search");
        2: getidx(vpn, "R6 random slot");
        3: begin
          int ix = s * WAYS + $urandom % WAYS;
          wr(2, 32'(ix)); cmd(5);
          chk(pd0_o == m_pd0[ix] && pd1_o == m_pd1[ix], "R9 random load", pd0_o, m_pd0[ix]);
        end
        default: begin
          int where;
          int c = m_count(vpn, asid, where);
          cmd(6);
          xlate(vpn, asid, c == 1, (c == 1) ? int'(m_pd1[where][24:6]) : 0, "R11 random translate");
        end
      endcase
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule